// File: doc/BRIEF.md
# Mirror-Based Universal Bit Shifter

This block moves an N-bit word by a variable distance in either direction. It supports three treatments of the vacated positions: zero fill, sign fill, and wrap-around. The only shifting hardware is a right-going logarithmic network. A left request is served by mirroring the word's bit order before the network and mirroring it back afterwards. The network has one layer per bit of the distance, and the largest distance comes first. Each layer moves the word only when its distance bit is set.

For an arithmetic left request, a small cell sits between the network and the final mirror. It overwrites the lowest bit of the network's result with the original top bit, so that after the final mirror the word keeps its sign in the most significant position. Asking for arithmetic and rotation together is not a defined operation. The block treats such a request as a rotation and raises a flag.

A parameter places a register on the outputs. With the register, results appear one clock after the inputs are presented. Without it, the datapath is purely combinational.

Top module: `ushift`

## Requirements
- R1: With dir_left=0, arith=0, rotate=0, data_out equals data_in moved right by amount places, with zeros entering at the top.
- R2: With dir_left=0, arith=1, rotate=0, data_out equals data_in moved right by amount places, with copies of data_in[N-1] entering at the top.
- R3: With dir_left=0, rotate=1, data_out equals data_in rotated right by amount places; the bits leaving bit 0 re-enter at bit N-1. The total count of ones is preserved.
- R4: With dir_left=1, arith=0, rotate=0, data_out equals data_in moved left with zeros entering at bit 0. With dir_left=1, rotate=1, data_out equals data_in rotated left.
- R5: With dir_left=1, arith=1, rotate=0, data_out equals the zero-filled left move of data_in, except that bit N-1 of data_out equals data_in[N-1].
- R6: An amount of 0 returns data_in unchanged for every legal combination of dir_left, arith and rotate.
- R7: arith=1 together with rotate=1 is illegal: illegal_op is 1 and data_out is the rotation in the direction given by dir_left. For every other combination, illegal_op is 0.
- R8: With REG_OUT=1, data_out and illegal_op are both registered. They take the result of the inputs present at a rising clock edge, hold it until the next edge, and are 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| data_in | input | N | Word to be moved |
| amount | input | $clog2(N) | Unsigned distance, 0 to N-1 |
| dir_left | input | 1 | 1 selects a left operation, 0 a right operation |
| arith | input | 1 | 1 selects sign-preserving treatment |
| rotate | input | 1 | 1 selects wrap-around |
| data_out | output | N | Moved word |
| illegal_op | output | 1 | 1 when arith and rotate are both set |

## Verification
The bench builds the block at its defaults: an 8-bit word, a 3-bit distance and the output register enabled. At 8 bits, every data value can be swept against an independent behavioural model. The sweep covers all eight distances and all six legal direction and mode pairs, so each fill source and each network layer combination is reached, including the sign-bit overwrite on arithmetic left moves. Hand-computed vectors cover the illegal combination, distance zero and sign-bit edge cases. Directed steps cover the reset value and the one-cycle hold of the output register.

// File: rtl/ushift.sv
module ushift #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int K      = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] data_in,
  input  logic [K-1:0] amount,
  input  logic         dir_left,
  input  logic         arith,
  input  logic         rotate,
  output logic [N-1:0] data_out,
  output logic         illegal_op
);

  logic         eff_arith;
  logic         fill_bit;
  logic [N-1:0] mirrored;
  logic [N-1:0] fixed;
  logic [N-1:0] result;
  logic [(K+1)*N-1:0] stg;

  assign eff_arith = arith & ~rotate;
  assign fill_bit  = eff_arith & ~dir_left & data_in[N-1];

  for (genvar p = 0; p < N/2; p++) begin : g_front_swap
    assign mirrored[p]     = dir_left ? data_in[N-1-p] : data_in[p];
    assign mirrored[N-1-p] = dir_left ? data_in[p]     : data_in[N-1-p];
  end

  assign stg[K*N +: N] = mirrored;

  for (genvar j = K-1; j >= 0; j--) begin : g_layer
    localparam int SH = 1 << j;
    for (genvar b = 0; b < N; b++) begin : g_bit
      if (b + SH < N) begin : g_move
        assign stg[j*N+b] = amount[j] ? stg[(j+1)*N+b+SH] : stg[(j+1)*N+b];
      end else begin : g_edge
        assign stg[j*N+b] = amount[j] ? (rotate ? stg[(j+1)*N+b+SH-N] : fill_bit)
                                      : stg[(j+1)*N+b];
      end
    end
  end

  assign fixed = {stg[N-1:1], (dir_left & eff_arith) ? data_in[N-1] : stg[0]};

  for (genvar p = 0; p < N/2; p++) begin : g_back_swap
    assign result[p]     = dir_left ? fixed[N-1-p] : fixed[p];
    assign result[N-1-p] = dir_left ? fixed[p]     : fixed[N-1-p];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_out   <= '0;
        illegal_op <= 1'b0;
      end else begin
        data_out   <= result;
        illegal_op <= arith & rotate;
      end
    end
  end else begin : g_comb
    assign data_out   = result;
    assign illegal_op = arith & rotate;
  end

endmodule

// File: rtl/ushift_chk.sv
module ushift_chk #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int K      = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] data_in,
  input logic [K-1:0] amount,
  input logic         dir_left,
  input logic         arith,
  input logic         rotate,
  input logic [N-1:0] data_out,
  input logic         illegal_op
);

  logic [N-1:0] q_d;
  logic [K-1:0] q_a;
  logic         q_l, q_ar, q_ro, seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_d <= '0; q_a <= '0; q_l <= 1'b0; q_ar <= 1'b0; q_ro <= 1'b0; seen <= 1'b0;
    end else begin
      q_d <= data_in; q_a <= amount; q_l <= dir_left;
      q_ar <= arith; q_ro <= rotate; seen <= 1'b1;
    end
  end

  logic [N-1:0] r_d;
  logic [K-1:0] r_a;
  logic         r_l, r_ar, r_ro, ok;

  assign r_d  = REG_OUT ? q_d  : data_in;
  assign r_a  = REG_OUT ? q_a  : amount;
  assign r_l  = REG_OUT ? q_l  : dir_left;
  assign r_ar = REG_OUT ? q_ar : arith;
  assign r_ro = REG_OUT ? q_ro : rotate;
  assign ok   = REG_OUT ? seen : 1'b1;

  assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (illegal_op == (r_ar && r_ro)));

  assert_zero_amount_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && r_a == '0 && !(r_ar && r_ro)) |-> (data_out == r_d));

  assert_rotate_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && r_ro) |-> ($countones(data_out) == $countones(r_d)));

  assert_logic_right_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !r_l && !r_ar && !r_ro && r_a != '0) |-> (data_out[N-1] == 1'b0));

  assert_arith_right_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !r_l && r_ar && !r_ro) |-> (data_out[N-1] == r_d[N-1]));

  assert_arith_left_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && r_l && r_ar && !r_ro) |-> (data_out[N-1] == r_d[N-1]));

  assert_logic_left_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && r_l && !r_ro && r_a != '0) |-> (data_out[0] == 1'b0));

endmodule

bind ushift ushift_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_in(data_in), .amount(amount),
  .dir_left(dir_left), .arith(arith), .rotate(rotate),
  .data_out(data_out), .illegal_op(illegal_op)
);

// File: tb/ushift_tb.sv
module ushift_tb;
  localparam int N = 8;
  localparam int K = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] data_in = '0;
  logic [K-1:0] amount = '0;
  logic dir_left = 1'b0, arith = 1'b0, rotate = 1'b0;
  logic [N-1:0] data_out;
  logic illegal_op;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  ushift #(.N(N), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .amount(amount),
    .dir_left(dir_left), .arith(arith), .rotate(rotate),
    .data_out(data_out), .illegal_op(illegal_op)
  );

  // {data, amount, left, arith, rotate, expected data, expected flag}
  localparam logic [22:0] VEC [8] = '{
    {8'hB4, 3'd3, 1'b0, 1'b0, 1'b0, 8'h16, 1'b0},
    {8'hB4, 3'd3, 1'b0, 1'b1, 1'b0, 8'hF6, 1'b0},
    {8'hB4, 3'd3, 1'b0, 1'b0, 1'b1, 8'h96, 1'b0},
    {8'hB4, 3'd3, 1'b1, 1'b0, 1'b0, 8'hA0, 1'b0},
    {8'h13, 3'd3, 1'b1, 1'b1, 1'b0, 8'h18, 1'b0},
    {8'hB4, 3'd3, 1'b1, 1'b0, 1'b1, 8'hA5, 1'b0},
    {8'hB4, 3'd3, 1'b0, 1'b1, 1'b1, 8'h96, 1'b1},
    {8'h80, 3'd0, 1'b1, 1'b1, 1'b0, 8'h80, 1'b0}
  };

  function automatic logic [N-1:0] model(logic [N-1:0] d, int s, logic l, logic ar, logic ro);
    logic [N-1:0] r;
    if (ro) r = l ? ((d << s) | (d >> (N - s))) : ((d >> s) | (d << (N - s)));
    else if (l) begin
      r = d << s;
      if (ar) r[N-1] = d[N-1];
    end else if (ar) r = $unsigned($signed(d) >>> s);
    else r = d >> s;
    if (s == 0) r = d;
    return r;
  endfunction

  function automatic string tag(int s, logic l, logic ar, logic ro);
    if (ar && ro) return "R7";
    if (s == 0) return "R6";
    if (l && ar) return "R5";
    if (l) return "R4";
    if (ro) return "R3";
    if (ar) return "R2";
    return "R1";
  endfunction

  task automatic check(string t, logic [N-1:0] exp_d, logic exp_f);
    checks++;
    if (data_out !== exp_d || illegal_op !== exp_f) begin
      fails++;
      $display("FAIL %s: got data=%h flag=%b, expected data=%h flag=%b",
               t, data_out, illegal_op, exp_d, exp_f);
    end
  endtask

  task automatic apply(logic [N-1:0] d, logic [K-1:0] a, logic l, logic ar, logic ro);
    data_in = d; amount = a; dir_left = l; arith = ar; rotate = ro;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles, expected fewer than 150000", cycles);
      finish_run();
    end
  end

  initial begin
    data_in = 8'hFF; arith = 1'b1; rotate = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [22:0] e;
      e = VEC[v];
      apply(e[22:15], e[14:12], e[11], e[10], e[9]);
      check(tag(int'(e[14:12]), e[11], e[10], e[9]), e[8:1], e[0]);
    end

    apply(8'h5A, 3'd1, 1'b0, 1'b0, 1'b0);
    data_in = 8'hC3; amount = 3'd2; dir_left = 1'b1;
    #2 check("R8 hold", 8'h2D, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R8 update", 8'h0C, 1'b0);

    for (int m = 0; m < 6; m++) begin
      logic l, ar, ro;
      l = m[0]; ar = (m >> 1) == 1; ro = (m >> 1) == 2;
      for (int a = 0; a < N; a++) begin
        for (int d = 0; d < 256; d++) begin
          apply(d[7:0], a[2:0], l, ar, ro);
          check(tag(a, l, ar, ro), model(d[7:0], a, l, ar, ro), 1'b0);
        end
      end
    end

    apply(8'h81, 3'd1, 1'b1, 1'b1, 1'b1);
    check("R7 left", 8'h03, 1'b1);

    rst_n = 1'b0;
    #2 check("R8 async reset", 8'h00, 1'b0);
    finish_run();
  end
endmodule